// File: doc/BRIEF.md
# Chained vector add-multiply pipeline

This block evaluates `dst[k] = (a[k] + b[k]) * c[k]` over 64-element vector registers using two pipelined functional units, an adder followed by a multiplier. Unsigned integer arithmetic stands in for floating point. Software or a surrounding controller first fills the three source register files through a load port: two addend vectors and one multiplicand vector. It then pulses `start`. When the run ends it reads the products back through a combinational read port on the destination register file.

Each unit accepts one element per cycle once its pipeline is full. The adder takes 8 cycles from issue to result: one cycle to move operands in, six cycles of arithmetic and one cycle to return the result. The multiplier takes 9 cycles: one in, seven of arithmetic and one to write back. The `chain_en` input is sampled when a run is accepted and selects one of two modes:

- **Chained mode:** every sum is forwarded into the multiplier in the cycle it appears, so the two units act as a single 17-stage pipeline.
- **Unchained mode:** all 64 sums are first parked in an intermediate vector, and the multiplier starts only after the last sum has arrived.

A one-cycle `done` pulse marks the write of the final product. The `cycle_count` output then holds the run's elapsed cycle count, which shows directly what chaining saves.

Top module: `vec_chain_mac`

## Requirements
- R1: After reset, `done` is 0 and `cycle_count` is 0. No work is issued until a start is accepted.
- R2: A load writes `ld_data` into element `ld_idx` of one source file, chosen by `ld_sel`:
  - 0 selects the first addend.
  - 1 selects the second addend.
  - 2 selects the multiplicand.
  - 3 writes nothing.
- R3: After a run, `rd_data` at index k equals `(a[k] + b[k]) * c[k]`. The sum is computed unsigned on 17 bits and the product on 33 bits, with no truncation.
- R4: In chained mode, the last product is written on the 80th rising edge after the edge that accepted `start` (8 + 9 + 63). `cycle_count` then reads 80.
- R5: In unchained mode, the last product is written on the 143rd rising edge after the accepted start (8 + 63 + 9 + 63). `cycle_count` then reads 143.
- R6: `done` is high for exactly one cycle, the cycle after the last product write. `cycle_count` increments by one per cycle while a run is in flight and holds its value until the next accepted start, which clears it to 0.
- R7: A `start` pulse while a run is in flight is ignored. It does not change the count, the results, or the number of `done` pulses.
- R8: In chained mode, the multiplier takes element k only in a cycle where the adder's valid strobe is high for element k.
- R9: In unchained mode, the multiplier takes no element before the adder's valid strobe for element 63 has appeared.
- R10: `chain_en` is sampled only at an accepted start. Changing it during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| chain_en | input | 1 | 1 selects chained timing, 0 selects unchained timing; sampled at an accepted start |
| ld_en | input | 1 | Source load strobe |
| ld_sel | input | 2 | Source file select: 0 first addend, 1 second addend, 2 multiplicand, 3 none |
| ld_idx | input | 6 | Element index for the load |
| ld_data | input | 16 | Load data |
| rd_idx | input | 6 | Destination element index |
| rd_data | output | 33 | Destination element at `rd_idx`, combinational |
| done | output | 1 | One-cycle pulse after the last product write |
| cycle_count | output | 16 | Elapsed cycles of the current or last run |

## Verification
The bench keeps its own behavioural timeline of each run. It records whether the start was accepted, which mode was sampled, and the edge on which the last product is due: edge 80 for chained runs and edge 143 for unchained runs. It compares `done` and `cycle_count` against that timeline at every falling edge, so an early or late pulse is caught on the exact cycle it occurs. The products are read only after `done`, one index per cycle, and compared against sums and products computed in the bench from its own copy of the loaded data. The element-by-element hand-off between the adder and the multiplier is internal, so it is checked by the bound properties rather than at the ports.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  // Source file selector for the load port.
  typedef enum logic [1:0] {
    SEL_ADDEND0 = 2'd0,
    SEL_ADDEND1 = 2'd1,
    SEL_MULCAND = 2'd2,
    SEL_NONE    = 2'd3
  } src_sel_e;

  // Edge of the last product write, counted from the accepted start edge.
  function automatic int chained_cycles(input int n, input int add_lat, input int mul_lat);
    return add_lat + mul_lat + n - 1;
  endfunction

  function automatic int unchained_cycles(input int n, input int add_lat, input int mul_lat);
    return (add_lat + n - 1) + (mul_lat + n - 1);
  endfunction

endpackage

// File: rtl/vcm_regfile.sv
module vcm_regfile #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/vcm_pipe.sv
// Fixed-latency pipeline: one element in per cycle, same element out DEPTH edges later.
module vcm_pipe #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  logic         stg_v [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) stg_v[g] <= 1'b0;
        else        stg_v[g] <= in_v;
      end
      always_ff @(posedge clk) begin
        stg_d[g] <= in_d;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) stg_v[g] <= 1'b0;
        else        stg_v[g] <= stg_v[g-1];
      end
      always_ff @(posedge clk) begin
        stg_d[g] <= stg_d[g-1];
      end
    end
  end

  assign out_v = stg_v[DEPTH-1];
  assign out_d = stg_d[DEPTH-1];

endmodule

// File: rtl/vcm_seq.sv
// Run control: start acceptance, element issue counters, cycle count, done pulse.
module vcm_seq #(
  parameter int NELEM = 64,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(NELEM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           chain_en,
  input  logic           add_vld,
  input  logic           add_last,
  input  logic           wr_v,
  input  logic           wr_last,
  output logic           busy,
  output logic           chain_q,
  output logic           add_issue,
  output logic [IDX_W:0] add_idx,
  output logic           mul_issue,
  output logic [IDX_W:0] mul_idx,
  output logic           sums_all,
  output logic [CNT_W-1:0] cyc,
  output logic           done
);

  localparam logic [IDX_W:0] N_L = (IDX_W+1)'(NELEM);

  assign add_issue = busy && (add_idx < N_L);
  assign mul_issue = chain_q ? (busy && add_vld)
                             : (busy && (mul_idx < N_L) && (sums_all || (add_vld && add_last)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      chain_q  <= 1'b0;
      add_idx  <= '0;
      mul_idx  <= '0;
      sums_all <= 1'b0;
      cyc      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          chain_q  <= chain_en;
          add_idx  <= '0;
          mul_idx  <= '0;
          sums_all <= 1'b0;
          cyc      <= '0;
        end
      end else begin
        cyc <= cyc + CNT_W'(1);
        if (add_issue) add_idx <= add_idx + (IDX_W+1)'(1);
        if (mul_issue) mul_idx <= mul_idx + (IDX_W+1)'(1);
        if (add_vld && add_last) sums_all <= 1'b1;
        if (wr_v && wr_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vec_chain_mac.sv
module vec_chain_mac #(
  parameter int NELEM   = 64,
  parameter int DW      = 16,
  parameter int ADD_LAT = 8,
  parameter int MUL_LAT = 9,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(NELEM),
  localparam int SUM_W  = DW + 1,
  localparam int RES_W  = SUM_W + DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             chain_en,
  input  logic             ld_en,
  input  logic [1:0]       ld_sel,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [DW-1:0]    ld_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RES_W-1:0] rd_data,
  output logic             done,
  output logic [CNT_W-1:0] cycle_count
);

  import vcm_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NELEM - 1);
  localparam int ADD_PW = IDX_W + SUM_W;
  localparam int MUL_PW = IDX_W + RES_W;

  function automatic logic [SUM_W-1:0] fn_sum(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return SUM_W'(x) + SUM_W'(y);
  endfunction

  function automatic logic [RES_W-1:0] fn_prod(input logic [SUM_W-1:0] s, input logic [DW-1:0] m);
    return RES_W'(s) * RES_W'(m);
  endfunction

  // Named internal events (also used by the bound checker)
  logic             busy, chain_q, sums_all;
  logic             add_issue, mul_issue;
  logic [IDX_W:0]   add_idx, mul_idx;
  logic             add_vld;
  logic [IDX_W-1:0] add_oidx;
  logic [SUM_W-1:0] add_sum;
  logic             add_last;
  logic             wr_v;
  logic [IDX_W-1:0] wr_idx;
  logic [RES_W-1:0] wr_data;
  logic             wr_last;
  logic [SUM_W-1:0] ibuf_rd;
  logic [SUM_W-1:0] mul_op;
  logic [DW-1:0]    src_rd [3];

  // Source register files: two addends read at the add issue index,
  // multiplicand read at the multiply issue index.
  for (genvar g = 0; g < 3; g++) begin : g_src
    localparam src_sel_e MY_SEL = src_sel_e'(g);
    logic [IDX_W-1:0] rsel;
    assign rsel = (MY_SEL == SEL_MULCAND) ? mul_idx[IDX_W-1:0] : add_idx[IDX_W-1:0];
    vcm_regfile #(.DEPTH(NELEM), .W(DW)) u_src (
      .clk  (clk),
      .we   (ld_en && (ld_sel == MY_SEL)),
      .waddr(ld_idx),
      .wdata(ld_data),
      .raddr(rsel),
      .rdata(src_rd[g])
    );
  end

  vcm_seq #(.NELEM(NELEM), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .chain_en (chain_en),
    .add_vld  (add_vld),
    .add_last (add_last),
    .wr_v     (wr_v),
    .wr_last  (wr_last),
    .busy     (busy),
    .chain_q  (chain_q),
    .add_issue(add_issue),
    .add_idx  (add_idx),
    .mul_issue(mul_issue),
    .mul_idx  (mul_idx),
    .sums_all (sums_all),
    .cyc      (cycle_count),
    .done     (done)
  );

  // Adder unit: transfer in, arithmetic, result return folded into ADD_LAT stages
  vcm_pipe #(.DEPTH(ADD_LAT), .W(ADD_PW)) u_add (
    .clk  (clk),
    .rst_n(rst_n),
    .in_v (add_issue),
    .in_d ({add_idx[IDX_W-1:0], fn_sum(src_rd[SEL_ADDEND0], src_rd[SEL_ADDEND1])}),
    .out_v(add_vld),
    .out_d({add_oidx, add_sum})
  );
  assign add_last = (add_oidx == LAST_IDX);

  // Intermediate vector: every sum is parked here in both modes
  vcm_regfile #(.DEPTH(NELEM), .W(SUM_W)) u_ibuf (
    .clk  (clk),
    .we   (add_vld),
    .waddr(add_oidx),
    .wdata(add_sum),
    .raddr(mul_idx[IDX_W-1:0]),
    .rdata(ibuf_rd)
  );

  // Chained: the sum is taken straight off the adder; unchained: from the intermediate vector
  assign mul_op = chain_q ? add_sum : ibuf_rd;

  // Multiplier: MUL_LAT-1 stages, the last cycle is the destination write
  vcm_pipe #(.DEPTH(MUL_LAT - 1), .W(MUL_PW)) u_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .in_v (mul_issue),
    .in_d ({mul_idx[IDX_W-1:0], fn_prod(mul_op, src_rd[SEL_MULCAND])}),
    .out_v(wr_v),
    .out_d({wr_idx, wr_data})
  );
  assign wr_last = (wr_idx == LAST_IDX);

  vcm_regfile #(.DEPTH(NELEM), .W(RES_W)) u_dst (
    .clk  (clk),
    .we   (wr_v),
    .waddr(wr_idx),
    .wdata(wr_data),
    .raddr(rd_idx),
    .rdata(rd_data)
  );

endmodule

// File: rtl/vcm_checker.sv
module vcm_checker #(
  parameter int NELEM   = 64,
  parameter int ADD_LAT = 8,
  parameter int MUL_LAT = 9,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(NELEM)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [CNT_W-1:0] cyc,
  input logic             busy,
  input logic             chain_q,
  input logic             add_issue,
  input logic             add_vld,
  input logic [IDX_W-1:0] add_oidx,
  input logic             mul_issue,
  input logic [IDX_W:0]   mul_idx,
  input logic             sums_all
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NELEM - 1);
  localparam logic [CNT_W-1:0] T_CH = CNT_W'(vcm_pkg::chained_cycles(NELEM, ADD_LAT, MUL_LAT));
  localparam logic [CNT_W-1:0] T_UN = CNT_W'(vcm_pkg::unchained_cycles(NELEM, ADD_LAT, MUL_LAT));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!add_issue && !mul_issue));

  assert_chain_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chain_q) |-> (cyc == T_CH));

  assert_unchain_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !chain_q) |-> (cyc == T_UN));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ((cyc - $past(cyc)) == CNT_W'(1)));

  assert_chain_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_issue && chain_q) |-> (add_vld && (add_oidx == mul_idx[IDX_W-1:0])));

  assert_unchain_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_issue && !chain_q) |-> (sums_all || (add_vld && (add_oidx == LAST_IDX))));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(chain_q));

endmodule

bind vec_chain_mac vcm_checker #(
  .NELEM(NELEM), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .CNT_W(CNT_W)
) u_vcm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .cyc      (cycle_count),
  .busy     (busy),
  .chain_q  (chain_q),
  .add_issue(add_issue),
  .add_vld  (add_vld),
  .add_oidx (add_oidx),
  .mul_issue(mul_issue),
  .mul_idx  (mul_idx),
  .sums_all (sums_all)
);

// File: tb/vec_chain_mac_bench.sv
module vec_chain_mac_bench;

  localparam int N     = 64;
  localparam int T_CH  = 8 + 9 + (N - 1);            // R4: 80
  localparam int T_UN  = (8 + (N - 1)) + (9 + (N - 1)); // R5: 143
  localparam int T_SEQ = N * 17;                      // element-at-a-time reference

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, chain_en = 1'b0, ld_en = 1'b0;
  logic [1:0]  ld_sel = 2'd0;
  logic [5:0]  ld_idx = '0, rd_idx = '0;
  logic [15:0] ld_data = '0;
  logic [32:0] rd_data;
  logic        done;
  logic [15:0] cycle_count;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  longint ea [N], eb [N], ec [N];

  always #4 clk = ~clk; // 125 MHz

  vec_chain_mac u_vec_chain_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_en(chain_en),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .done(done), .cycle_count(cycle_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural timeline of a run, advanced on every rising edge
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0, m_target = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_cnt <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        m_cnt <= m_cnt + 1;
        if (m_cnt + 1 == m_target) begin
          m_busy <= 0;
          m_done <= 1;
        end
      end else if (start) begin
        m_busy   <= 1;
        m_cnt    <= 0;
        m_target <= chain_en ? T_CH : T_UN; // R10: sampled only here
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done == m_done, "R6 done pulse (R4 R5 timing)", done, m_done);
      chk(cycle_count == m_cnt, "R6 cycle_count (R4 R5 R7)", cycle_count, m_cnt);
    end
  end

  task automatic load(input logic [1:0] sel, input int idx, input longint val);
    @(negedge clk);
    ld_en = 1; ld_sel = sel; ld_idx = 6'(idx); ld_data = 16'(val);
    @(negedge clk);
    ld_en = 0;
    case (sel)
      2'd0: ea[idx] = val & 16'hFFFF;
      2'd1: eb[idx] = val & 16'hFFFF;
      2'd2: ec[idx] = val & 16'hFFFF;
      default: ;
    endcase
  endtask

  task automatic run(input bit chain, input bit disturb, input string req);
    int waited = 0;
    @(negedge clk);
    start = 1; chain_en = chain;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      chain_en = ~chain;                 // R10
      repeat (20) @(negedge clk);
      start = 1;                         // R7
      @(negedge clk);
      start = 0;
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      chain_en = chain;
    end
    while (!done && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, {req, " done seen"}, done, 1);
    chk(cycle_count == (chain ? T_CH : T_UN), {req, " final count"}, cycle_count, chain ? T_CH : T_UN);
    for (int k = 0; k < N; k++) begin
      longint exp;
      @(negedge clk);
      rd_idx = 6'(k);
      #1;
      exp = (ea[k] + eb[k]) * ec[k];
      chk(rd_data == 33'(exp), "R3 product", rd_data, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    $display("element-at-a-time reference: %0d cycles", T_SEQ);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(cycle_count == 16'd0, "R1 reset count", cycle_count, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(cycle_count == 16'd0, "R1 idle count", cycle_count, 0);

    // Pattern 1: mixed values, chained (R2 R3 R4 R6 R8)
    for (int k = 0; k < N; k++) begin
      load(2'd0, k, (k * 37 + 5) % 65536);
      load(2'd1, k, (k * 1021 + 300) % 65536);
      load(2'd2, k, (k * 7 + 1) % 65536);
    end
    run(1'b1, 1'b0, "R4 chained");
    repeat (12) @(negedge clk); // R6 count holds

    // Pattern 2: all-ones boundary, unchained (R3 R5 R9)
    for (int k = 0; k < N; k++) begin
      load(2'd0, k, 65535);
      load(2'd1, k, 65535);
      load(2'd2, k, (k == 0) ? 0 : 65535);
    end
    run(1'b0, 1'b0, "R5 unchained");

    // Only the multiplicand changes; select 3 writes nothing (R2)
    for (int k = 0; k < N; k++) load(2'd2, k, (k * 913 + 17) % 65536);
    load(2'd3, 5, 16'h1234);
    load(2'd3, 63, 16'h0);
    run(1'b1, 1'b1, "R2 R7 R10 chained, disturbed");

    // Unchained with disturbances and new addends (R7 R10 R9)
    for (int k = 0; k < N; k++) load(2'd1, k, (k * 4099) % 65536);
    run(1'b0, 1'b1, "R7 R10 unchained, disturbed");
    repeat (10) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule